// File: doc/BRIEF.md
# Reload down-counter timer

A peripheral with up to eight 32-bit channels that count down on their own. Each channel has a reload value, a live count and a small control word. One shared byte register starts and stops the channels, one bit per channel. Each channel's clock is a division of the system clock by 4, 16, 64 or 256, chosen per channel.

When a channel's count is zero at a prescaled tick, the channel reloads from its reload value and sets a sticky underflow flag. The channel's interrupt line is high while that flag and the channel's interrupt enable are both set. Software clears the flag by writing its bit as zero. The count runs downward, so inverting it gives an elapsed-tick value. A reload value of all ones gives the longest period. A small reload value gives a periodic event.

Access goes over a plain synchronous register bus. Reads are combinational. Writes take effect at the next rising clock edge. Byte address 0x00 is the start register. Channel n (counting from 0) occupies the 16-byte slot at 0x10·(n+1): the reload value is at offset 0x0, the count at 0x4 and the control word at 0x8.

Top module: `mchan_down_timer`

## Requirements
- R1: After reset every register reads 0 and every interrupt line is low.
- R2: Reload and count registers read back the full 32-bit value written. The control word keeps only bits [2:0] (divider code), bit 5 (interrupt enable) and bit 8 (flag), and every other bit reads 0. An address that decodes to no register reads 0.
- R3: Bit n of the start register at 0x00 runs channel n when set and stops it when clear. Bits at and above the channel count read 0.
- R4: A running channel decrements by one on each prescaled tick. Divider code bits [1:0] select the division: 0 gives /4, 1 gives /16, 2 gives /64 and 3 gives /256. Code bit 2 does not change the division. The first tick falls on the D-th rising edge after the edge that writes the start bit, where D is the division.
- R5: On a tick where the count is 0, the count loads the reload value and the flag is set, so a reload value C gives a period of C+1 ticks. A reload value of 0xFFFFFFFF is loaded unchanged.
- R6: While a channel is stopped, its count holds. Its reload and count registers stay writable. After a restart, counting resumes from the written count, and the divider starts again from zero.
- R7: Writing the control word with bit 8 at 0 clears the flag, and writing it with bit 8 at 1 leaves the flag unchanged. An underflow in the same cycle as a clearing write leaves the flag set.
- R8: Interrupt line n equals flag AND interrupt enable of channel n. It is a level that stays high until the flag or the enable is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data, valid in the same cycle |
| irq | output | NUM_CH | Per-channel level interrupt |

## Verification
Read data is combinational, so each read is checked 1 ns after inputs change at a falling edge, inside the same cycle. A write is counted as applied at the rising edge that follows it. The first tick after a start write is due D rising edges later, so the bench reads the count one cycle before and one cycle after that edge, for every divider code. The flag and the interrupt change at the edge of the zero-count tick, and the bench samples them one cycle after that edge. Each bus operation in the bench takes exactly one clock edge, so the expected values in the table follow from counting operations.

// File: rtl/mchan_down_timer.sv
module mchan_down_timer #(
  parameter int NUM_CH = 3,
  parameter int DW     = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [7:0]        bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  output logic [NUM_CH-1:0] irq
);
  localparam logic [3:0] OFS_CST = 4'h0;
  localparam logic [3:0] OFS_CNT = 4'h4;
  localparam logic [3:0] OFS_CTL = 4'h8;

  logic [NUM_CH-1:0]         run_q, flg_q, ie_q, tick, unf;
  logic [NUM_CH-1:0][2:0]    psc_q;
  logic [NUM_CH-1:0][7:0]    pre_q;
  logic [NUM_CH-1:0][DW-1:0] cst_q, cnt_q;
  logic                      wr_any;

  function automatic logic [7:0] div_mask(input logic [1:0] code);
    return 8'((4 << (2 * int'(code))) - 1);
  endfunction

  function automatic logic hit(input logic [7:0] a, input int n, input logic [3:0] ofs);
    return (a[7:4] == 4'(n + 1)) && (a[3:0] == ofs);
  endfunction

  assign wr_any = bus_sel & bus_wr;
  assign irq    = flg_q & ie_q;

  always_comb begin
    for (int n = 0; n < NUM_CH; n++) begin
      tick[n] = run_q[n] && ((pre_q[n] & div_mask(psc_q[n][1:0])) == div_mask(psc_q[n][1:0]));
      unf[n]  = tick[n] && (cnt_q[n] == '0);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
      flg_q <= '0;
      ie_q  <= '0;
      psc_q <= '0;
      pre_q <= '0;
      cst_q <= '0;
      cnt_q <= '0;
    end else begin
      if (wr_any && bus_addr == 8'h00) run_q <= bus_wdata[NUM_CH-1:0];
      for (int n = 0; n < NUM_CH; n++) begin
        pre_q[n] <= run_q[n] ? pre_q[n] + 8'd1 : 8'd0;
        if (wr_any && hit(bus_addr, n, OFS_CST)) cst_q[n] <= bus_wdata;
        if (wr_any && hit(bus_addr, n, OFS_CNT)) cnt_q[n] <= bus_wdata;
        else if (unf[n])                         cnt_q[n] <= cst_q[n];
        else if (tick[n])                        cnt_q[n] <= cnt_q[n] - DW'(1);
        if (wr_any && hit(bus_addr, n, OFS_CTL)) begin
          psc_q[n] <= bus_wdata[2:0];
          ie_q[n]  <= bus_wdata[5];
        end
        if (unf[n])                                                  flg_q[n] <= 1'b1;
        else if (wr_any && hit(bus_addr, n, OFS_CTL) && !bus_wdata[8]) flg_q[n] <= 1'b0;
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_sel && !bus_wr) begin
      if (bus_addr == 8'h00) bus_rdata[NUM_CH-1:0] = run_q;
      for (int n = 0; n < NUM_CH; n++) begin
        if (hit(bus_addr, n, OFS_CST)) bus_rdata = cst_q[n];
        if (hit(bus_addr, n, OFS_CNT)) bus_rdata = cnt_q[n];
        if (hit(bus_addr, n, OFS_CTL)) bus_rdata = DW'({flg_q[n], 2'b00, ie_q[n], 2'b00, psc_q[n]});
      end
    end
  end
endmodule

// File: rtl/mchan_down_timer_chk.sv
module mchan_down_timer_chk #(
  parameter int NUM_CH = 3,
  parameter int DW     = 32
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      bus_sel,
  input logic                      bus_wr,
  input logic [7:0]                bus_addr,
  input logic [DW-1:0]             bus_wdata,
  input logic [DW-1:0]             bus_rdata,
  input logic [NUM_CH-1:0]         irq,
  input logic [NUM_CH-1:0]         run_q,
  input logic [NUM_CH-1:0]         flg_q,
  input logic [NUM_CH-1:0][DW-1:0] cst_q,
  input logic [NUM_CH-1:0][DW-1:0] cnt_q
);
  a_r3_start_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && bus_addr == 8'h00) |-> ((bus_rdata >> NUM_CH) == '0));

  for (genvar n = 0; n < NUM_CH; n++) begin : g_chk
    localparam logic [7:0] A_CNT = 8'((n + 1) * 16 + 4);
    localparam logic [7:0] A_CTL = 8'((n + 1) * 16 + 8);

    a_r2_ctl_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && !bus_wr && bus_addr == A_CTL) |-> ((bus_rdata & ~DW'(32'h127)) == '0));

    a_r6_hold_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_q[n] && !(bus_sel && bus_wr && bus_addr == A_CNT)) |=> $stable(cnt_q[n]));

    a_r5_step_or_reload: assert property (@(posedge clk) disable iff (!rst_n)
      (!$stable(cnt_q[n]) && !$past(bus_sel && bus_wr && bus_addr == A_CNT)) |->
      ((cnt_q[n] == $past(cnt_q[n]) - DW'(1)) ||
       ($past(cnt_q[n]) == '0 && cnt_q[n] == $past(cst_q[n]))));

    a_r7_flag_clear_by_write: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(flg_q[n]) |-> $past(bus_sel && bus_wr && bus_addr == A_CTL && !bus_wdata[8]));

    a_r8_irq_level_holds: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(irq[n]) |-> $past(bus_sel && bus_wr && bus_addr == A_CTL));
  end
endmodule

bind mchan_down_timer mchan_down_timer_chk #(.NUM_CH(NUM_CH), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .irq(irq), .run_q(run_q), .flg_q(flg_q), .cst_q(cst_q), .cnt_q(cnt_q)
);

// File: tb/mchan_down_timer_tb.sv
`timescale 1ns/1ps
module mchan_down_timer_tb;
  localparam int NUM_CH = 3;
  localparam int DW     = 32;
  localparam int NV     = 37;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              bus_sel = 1'b0, bus_wr = 1'b0;
  logic [7:0]        bus_addr = '0;
  logic [DW-1:0]     bus_wdata = '0;
  logic [DW-1:0]     bus_rdata;
  logic [NUM_CH-1:0] irq;
  int                n_chk = 0, n_bad = 0;

  mchan_down_timer #(.NUM_CH(NUM_CH), .DW(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  always #2.5 clk = ~clk;

  // kind[48:47] 0 write / 1 read / 2 idle, addr[46:39], data[38:7], irq[6:4], req[3:0]
  localparam logic [48:0] VEC [NV] = '{
    {2'd0, 8'h10, 32'h5,   3'b000, 4'd2},  // R2 reload ch0
    {2'd0, 8'h14, 32'h2,   3'b000, 4'd2},  // R2 count ch0
    {2'd0, 8'h18, 32'h20,  3'b000, 4'd2},  // R2 enable irq, /4
    {2'd0, 8'h00, 32'h1,   3'b000, 4'd3},  // R3 start ch0
    {2'd1, 8'h14, 32'h2,   3'b000, 4'd4},  // R4
    {2'd2, 8'h00, 32'd2,   3'b000, 4'd4},
    {2'd1, 8'h14, 32'h2,   3'b000, 4'd4},  // R4 just before first tick
    {2'd1, 8'h14, 32'h1,   3'b000, 4'd4},  // R4 after first tick
    {2'd2, 8'h00, 32'd2,   3'b000, 4'd4},
    {2'd1, 8'h14, 32'h1,   3'b000, 4'd4},
    {2'd1, 8'h14, 32'h0,   3'b000, 4'd4},
    {2'd1, 8'h18, 32'h20,  3'b000, 4'd8},  // R8 no flag yet
    {2'd2, 8'h00, 32'd1,   3'b000, 4'd5},
    {2'd1, 8'h18, 32'h20,  3'b000, 4'd5},  // R5 before underflow
    {2'd1, 8'h18, 32'h120, 3'b001, 4'd5},  // R5 flag set, irq high
    {2'd1, 8'h14, 32'h5,   3'b001, 4'd5},  // R5 reloaded
    {2'd0, 8'h18, 32'h120, 3'b000, 4'd7},  // R7 write 1 to flag
    {2'd1, 8'h18, 32'h120, 3'b001, 4'd7},  // R7 flag kept
    {2'd0, 8'h18, 32'h20,  3'b000, 4'd7},  // R7 write 0 clears
    {2'd1, 8'h18, 32'h20,  3'b000, 4'd7},
    {2'd0, 8'h00, 32'h0,   3'b000, 4'd6},  // R6 stop
    {2'd1, 8'h14, 32'h4,   3'b000, 4'd6},
    {2'd2, 8'h00, 32'd8,   3'b000, 4'd6},
    {2'd1, 8'h14, 32'h4,   3'b000, 4'd6},  // R6 held
    {2'd0, 8'h14, 32'h3,   3'b000, 4'd6},
    {2'd0, 8'h10, 32'h7,   3'b000, 4'd6},
    {2'd1, 8'h14, 32'h3,   3'b000, 4'd6},
    {2'd0, 8'h00, 32'h1,   3'b000, 4'd6},  // R6 restart
    {2'd1, 8'h14, 32'h3,   3'b000, 4'd6},
    {2'd2, 8'h00, 32'd2,   3'b000, 4'd6},
    {2'd1, 8'h14, 32'h3,   3'b000, 4'd6},  // R6 divider restarted
    {2'd1, 8'h14, 32'h2,   3'b000, 4'd6},
    {2'd1, 8'h00, 32'h1,   3'b000, 4'd3},  // R3
    {2'd0, 8'h00, 32'hFF,  3'b000, 4'd3},
    {2'd1, 8'h00, 32'h7,   3'b000, 4'd3},  // R3 upper bits read 0
    {2'd0, 8'h00, 32'h1,   3'b000, 4'd3},
    {2'd1, 8'h14, 32'h1,   3'b000, 4'd4}   // R4 ch0 unaffected
  };

  task automatic wr(input logic [7:0] a, input logic [DW-1:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [DW-1:0] exp_d,
                    input logic [NUM_CH-1:0] exp_irq, input string tag);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1;
    n_chk++;
    if (bus_rdata !== exp_d || irq !== exp_irq) begin
      n_bad++;
      $display("FAIL %s addr=%h: actual data=%h irq=%b expected data=%h irq=%b",
               tag, a, bus_rdata, irq, exp_d, exp_irq);
    end
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    bus_sel = 1'b0; bus_wr = 1'b0;
    rst_n = 1'b0;
    idle(3);
    rst_n = 1'b1;
  endtask

  initial begin
    #1ms;
    n_bad++;
    $display("FAIL R1 watchdog: actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    do_reset();
    // R1 reset state
    rd(8'h00, '0, '0, "R1");
    for (int c = 0; c < NUM_CH; c++) begin
      rd(8'((c + 1) * 16),     '0, '0, "R1");
      rd(8'((c + 1) * 16 + 4), '0, '0, "R1");
      rd(8'((c + 1) * 16 + 8), '0, '0, "R1");
    end

    for (int i = 0; i < NV; i++) begin
      logic [48:0] v;
      v = VEC[i];
      case (v[48:47])
        2'd0: wr(v[46:39], v[38:7]);
        2'd1: rd(v[46:39], v[38:7], v[6:4], $sformatf("R%0d", v[3:0]));
        default: idle(int'(v[38:7]));
      endcase
    end

    // R4 divider codes, bit 2 ignored
    foreach (VEC[k]) if (k < 4) begin
      logic [2:0] code;
      int d;
      code = (k == 0) ? 3'd1 : (k == 1) ? 3'd2 : (k == 2) ? 3'd3 : 3'd5;
      d = 1 << (2 + 2 * int'(code[1:0]));
      do_reset();
      wr(8'h24, 32'h1);
      wr(8'h28, DW'(code));
      wr(8'h00, 32'h2);
      idle(d - 1);
      rd(8'h24, 32'h1, '0, "R4");
      rd(8'h24, 32'h0, '0, "R4");
    end

    // R7 underflow wins over same-cycle clear; R8 irq needs enable
    do_reset();
    wr(8'h00, 32'h1);
    idle(3);
    wr(8'h18, 32'h0);
    rd(8'h18, 32'h100, '0, "R7");
    wr(8'h18, 32'h0);
    rd(8'h18, 32'h0, '0, "R7");
    idle(1);
    rd(8'h18, 32'h100, '0, "R8");
    wr(8'h18, 32'h120);
    rd(8'h18, 32'h120, 3'b001, "R8");

    // R5 longest period reload
    do_reset();
    wr(8'h10, 32'hFFFF_FFFF);
    wr(8'h00, 32'h1);
    idle(4);
    rd(8'h14, 32'hFFFF_FFFF, '0, "R5");
    idle(2);
    rd(8'h14, 32'hFFFF_FFFF, '0, "R5");
    rd(8'h14, 32'hFFFF_FFFE, '0, "R5");

    // R2 readback and reserved bits
    do_reset();
    wr(8'h30, 32'hA5C3_0F96);
    rd(8'h30, 32'hA5C3_0F96, '0, "R2");
    wr(8'h38, 32'hFFFF_FFFF);
    rd(8'h38, 32'h27, '0, "R2");
    rd(8'h40, 32'h0, '0, "R2");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule